// File: doc/BRIEF.md
# Keypad Event Host-Read Slave Port

This block is the two-wire serial slave through which a host processor reads a keypress event store. It runs entirely in the system clock domain. SCL and SDA are oversampled through synchronizers, and START and STOP conditions are recognised on the synchronized samples. The block answers a 7-bit address whose upper five bits are fixed and whose lower two bits come from two strap pins, so four such ports can share one bus.

There is no register pointer. A write transaction carries one data byte, and that byte lands in the single control register. A read transaction always streams the same four-byte frame:

1. the chip identifier,
2. the control register,
3. the key byte at the head of the event FIFO,
4. the duration byte at the head of the event FIFO.

The FIFO is told to advance by a one-cycle pop strobe. The strobe is raised only when the master acknowledges the duration byte. If the master stops early or answers with a not-acknowledge, the same event is returned on the next read.

The control register has three roles:

- It holds a drive-enable bit for the external sense network.
- It turns a write of the power-down bit into a one-cycle clear pulse for the FIFO and the duration timer.
- It reports the FIFO-empty flag on reads.

The port gives only an open-drain enable for SDA. The pad, clock stretching and glitch filtering belong elsewhere.

Top module: `keyremote_i2c_slave`

## Requirements
- R1: The port acknowledges an address byte whose upper seven bits equal binary 01000 followed by addr_pins[1] and then addr_pins[0]. For any other address it leaves SDA released (sda_oe = 0) for the acknowledge bit and for the rest of the transaction.
- R2: A STOP (SDA rising while SCL is high) releases SDA and ends the transaction. A START (SDA falling while SCL is high), including a repeated START after a write, begins a new address phase.
- R3: SDA as driven by the port changes only while SCL is low. Every byte is sent most significant bit first, with the acknowledge on the ninth clock.
- R4: A write consists of the address byte with R/W = 0 followed by one data byte. The port acknowledges both bytes. Data bit 7 is loaded into force_en, where 1 means normal drive and 0 means high impedance.
- R5: A read (R/W = 1) returns four bytes in fixed order: the chip identifier 0x00, the control register, fifo_key, and fifo_dur.
- R6: fifo_pop pulses for exactly one cycle when the master acknowledges the duration byte. A not-acknowledge, or acknowledges of the first three bytes, produce no pop, so the next read returns the same key and duration.
- R7: The control byte reads as follows:
  - bit 7: force_en
  - bit 6: 0
  - bit 5: the fifo_empty input
  - bits 4 to 0: 0

  Written values of bits 5 to 0 have no effect on what is read back.
- R8: Writing a control byte with bit 6 = 1 raises fifo_clear for exactly one cycle. A write with bit 6 = 0 raises no pulse.
- R9: After reset, sda_oe = 0, force_en = 1, fifo_pop = 0 and fifo_clear = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock as seen at the pad |
| sda_i | input | 1 | Bus data as seen at the pad |
| sda_oe | output | 1 | 1 = pull SDA low |
| addr_pins | input | 2 | Strap levels for address bits 1 and 0 |
| fifo_key | input | 8 | Key byte at FIFO head |
| fifo_dur | input | 8 | Duration byte at FIFO head |
| fifo_empty | input | 1 | FIFO holds no event |
| fifo_pop | output | 1 | One-cycle advance strobe to the FIFO |
| fifo_clear | output | 1 | One-cycle clear to FIFO and timer |
| force_en | output | 1 | Sense drive enable (control bit 7) |

## Verification
The hardest situation to reach is a read in which the master refuses the duration byte and the same event must then come back intact. It is just as hard to prove that acknowledges of the earlier bytes never advance the FIFO.

The bench models the FIFO head as a counter that moves only on fifo_pop and that feeds distinct key and duration values. It then runs three reads back to back:

- a read that ends with a not-acknowledge on the duration byte,
- a read cut short after the control byte,
- a full acknowledged read.

It compares the returned bytes and the pop count after each one. A repeated START placed directly after a write's acknowledge checks that the port re-enters the address phase without a STOP.

// File: rtl/kr_i2c_pkg.sv
package kr_i2c_pkg;
    localparam int unsigned BYTE_BITS   = 8;
    localparam int unsigned FRAME_BYTES = 4;
    localparam int unsigned IDX_W       = $clog2(FRAME_BYTES);
    localparam int unsigned CNT_W       = $clog2(BYTE_BITS + 1);

    // control byte field positions
    localparam int unsigned CTL_FORCE = 7;
    localparam int unsigned CTL_CLEAR = 6;
    localparam int unsigned CTL_EMPTY = 5;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RACK
    } eng_state_t;
endpackage

// File: rtl/kr_bus_sampler.sv
module kr_bus_sampler #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [1:0] raw;
    logic [1:0] synced;
    assign raw = {sda_i, scl_i};

    for (genvar g = 0; g < 2; g++) begin : g_sync
        logic [STAGES-1:0] chain_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '1;
            else        chain_q <= {chain_q[STAGES-2:0], raw[g]};
        end
        assign synced[g] = chain_q[STAGES-1];
    end

    logic scl_prev_q, sda_prev_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_prev_q <= 1'b1;
            sda_prev_q <= 1'b1;
        end else begin
            scl_prev_q <= synced[0];
            sda_prev_q <= synced[1];
        end
    end

    assign scl_s     = synced[0];
    assign sda_s     = synced[1];
    assign scl_rise  = synced[0] & ~scl_prev_q;
    assign scl_fall  = ~synced[0] & scl_prev_q;
    assign start_det = synced[0] & scl_prev_q & sda_prev_q & ~synced[1];
    assign stop_det  = synced[0] & scl_prev_q & ~sda_prev_q & synced[1];
endmodule

// File: rtl/kr_ctrl_reg.sv
module kr_ctrl_reg
    import kr_i2c_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [1:0] wr_bits,     // {force, clear}
    input  logic       fifo_empty,
    output logic       force_en,
    output logic       clear_pulse,
    output logic [7:0] rd_value
);
    typedef struct packed {
        logic force_en;
        logic clear;
    } ctl_t;

    ctl_t r_q, r_d;

    always_comb begin
        r_d       = r_q;
        r_d.clear = 1'b0;
        if (wr_en) begin
            r_d.force_en = wr_bits[1];
            r_d.clear    = wr_bits[0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{force_en: 1'b1, clear: 1'b0};
        else        r_q <= r_d;
    end

    always_comb begin
        rd_value            = '0;
        rd_value[CTL_FORCE] = r_q.force_en;
        rd_value[CTL_EMPTY] = fifo_empty;
    end

    assign force_en    = r_q.force_en;
    assign clear_pulse = r_q.clear;

    // R4: force bit follows the written value
    p_force_follows_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (force_en == $past(wr_bits[1])));
    // R8: clear lasts a single cycle
    p_clear_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        clear_pulse |=> !clear_pulse);
endmodule

// File: rtl/kr_i2c_engine.sv
module kr_i2c_engine
    import kr_i2c_pkg::*;
#(
    parameter logic [4:0] ADDR_PREFIX = 5'b01000,
    parameter logic [7:0] CHIP_ID     = 8'h00
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_s,
    input  logic       sda_s,
    input  logic       scl_rise,
    input  logic       scl_fall,
    input  logic       start_det,
    input  logic       stop_det,
    input  logic [1:0] addr_pins,
    input  logic [7:0] ctrl_rd,
    input  logic [7:0] fifo_key,
    input  logic [7:0] fifo_dur,
    output logic       sda_oe,
    output logic       fifo_pop,
    output logic       ctrl_wr,
    output logic [1:0] ctrl_wbits
);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_BITS);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(FRAME_BYTES - 1);

    typedef struct packed {
        eng_state_t       state;
        logic [CNT_W-1:0] bitcnt;
        logic [7:0]       shreg;
        logic             oe;
        logic             rw;
        logic [IDX_W-1:0] idx;
        logic             acked;
        logic             pop;
        logic             wr;
    } eng_t;

    eng_t r_q, r_d;

    // byte chosen for the next load
    logic [IDX_W-1:0] sel_idx;
    logic [7:0]       sel_byte;
    always_comb begin
        sel_idx = (r_q.state == ST_ADDR_ACK) ? '0 : r_q.idx + IDX_W'(1);
        case (sel_idx)
            IDX_W'(0): sel_byte = CHIP_ID;
            IDX_W'(1): sel_byte = ctrl_rd;
            IDX_W'(2): sel_byte = fifo_key;
            default:   sel_byte = fifo_dur;
        endcase
    end

    always_comb begin
        r_d     = r_q;
        r_d.pop = 1'b0;
        r_d.wr  = 1'b0;
        if (stop_det) begin
            r_d.state = ST_IDLE;
            r_d.oe    = 1'b0;
        end else if (start_det) begin
            r_d.state  = ST_ADDR;
            r_d.bitcnt = '0;
            r_d.oe     = 1'b0;
        end else begin
            case (r_q.state)
                ST_ADDR, ST_WDATA: begin
                    if (scl_rise) begin
                        r_d.shreg  = {r_q.shreg[6:0], sda_s};
                        r_d.bitcnt = r_q.bitcnt + CNT_W'(1);
                    end else if (scl_fall && r_q.bitcnt == FULL) begin
                        if (r_q.state == ST_WDATA) begin
                            r_d.wr    = 1'b1;
                            r_d.oe    = 1'b1;
                            r_d.state = ST_WDATA_ACK;
                        end else if (r_q.shreg[7:1] == {ADDR_PREFIX, addr_pins}) begin
                            r_d.oe    = 1'b1;
                            r_d.rw    = r_q.shreg[0];
                            r_d.state = ST_ADDR_ACK;
                        end else begin
                            r_d.state = ST_IDLE;
                        end
                    end
                end
                ST_ADDR_ACK: begin
                    if (scl_fall) begin
                        r_d.bitcnt = '0;
                        if (r_q.rw) begin
                            r_d.idx   = '0;
                            r_d.shreg = sel_byte;
                            r_d.oe    = ~sel_byte[7];
                            r_d.state = ST_RDATA;
                        end else begin
                            r_d.oe    = 1'b0;
                            r_d.state = ST_WDATA;
                        end
                    end
                end
                ST_WDATA_ACK: begin
                    if (scl_fall) begin
                        r_d.oe    = 1'b0;
                        r_d.state = ST_IDLE;
                    end
                end
                ST_RDATA: begin
                    if (scl_rise) begin
                        r_d.bitcnt = r_q.bitcnt + CNT_W'(1);
                    end else if (scl_fall) begin
                        if (r_q.bitcnt == FULL) begin
                            r_d.oe    = 1'b0;
                            r_d.acked = 1'b0;
                            r_d.state = ST_RACK;
                        end else begin
                            r_d.shreg = {r_q.shreg[6:0], 1'b0};
                            r_d.oe    = ~r_q.shreg[6];
                        end
                    end
                end
                ST_RACK: begin
                    if (scl_rise) begin
                        r_d.acked = ~sda_s;
                        r_d.pop   = ~sda_s && (r_q.idx == LAST);
                    end else if (scl_fall) begin
                        if (r_q.acked && r_q.idx != LAST) begin
                            r_d.idx    = sel_idx;
                            r_d.shreg  = sel_byte;
                            r_d.oe     = ~sel_byte[7];
                            r_d.bitcnt = '0;
                            r_d.state  = ST_RDATA;
                        end else begin
                            r_d.state = ST_IDLE;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{state: ST_IDLE, default: '0};
        else        r_q <= r_d;
    end

    assign sda_oe     = r_q.oe;
    assign fifo_pop   = r_q.pop;
    assign ctrl_wr    = r_q.wr;
    assign ctrl_wbits = r_q.shreg[7:6];

    // R3: driven data only moves while SCL is low
    p_sda_moves_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> $past(!scl_s));
    // R2: STOP releases the line
    p_stop_releases_r2: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !sda_oe);
    // R6: pop only follows a sampled acknowledge
    p_pop_on_ack_r6: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_pop |-> $past(scl_s && !sda_s));
    // R6: pop is a single-cycle strobe
    p_pop_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_pop |=> !fifo_pop);
endmodule

// File: rtl/keyremote_i2c_slave.sv
module keyremote_i2c_slave
    import kr_i2c_pkg::*;
#(
    parameter logic [4:0]  ADDR_PREFIX = 5'b01000,
    parameter logic [7:0]  CHIP_ID     = 8'h00,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_oe,
    input  logic [1:0] addr_pins,
    input  logic [7:0] fifo_key,
    input  logic [7:0] fifo_dur,
    input  logic       fifo_empty,
    output logic       fifo_pop,
    output logic       fifo_clear,
    output logic       force_en
);
    logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic ctrl_wr;
    logic [1:0] ctrl_wbits;
    logic [7:0] ctrl_rd;

    kr_bus_sampler #(.STAGES(SYNC_STAGES)) u_sampler (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    kr_i2c_engine #(.ADDR_PREFIX(ADDR_PREFIX), .CHIP_ID(CHIP_ID)) u_engine (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_s      (scl_s),
        .sda_s      (sda_s),
        .scl_rise   (scl_rise),
        .scl_fall   (scl_fall),
        .start_det  (start_det),
        .stop_det   (stop_det),
        .addr_pins  (addr_pins),
        .ctrl_rd    (ctrl_rd),
        .fifo_key   (fifo_key),
        .fifo_dur   (fifo_dur),
        .sda_oe     (sda_oe),
        .fifo_pop   (fifo_pop),
        .ctrl_wr    (ctrl_wr),
        .ctrl_wbits (ctrl_wbits)
    );

    kr_ctrl_reg u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (ctrl_wr),
        .wr_bits     (ctrl_wbits),
        .fifo_empty  (fifo_empty),
        .force_en    (force_en),
        .clear_pulse (fifo_clear),
        .rd_value    (ctrl_rd)
    );
endmodule

// File: tb/tb_keyremote_i2c_slave.sv
`timescale 1ns/1ps
module tb_keyremote_i2c_slave;
    localparam int Q = 25;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1, sda_m = 1'b1;
    logic sda_oe, fifo_pop, fifo_clear, force_en;
    logic [1:0] addr_pins = 2'b01;
    logic [7:0] head = 8'd0;
    logic fifo_empty = 1'b0;
    logic sda_bus;
    logic [7:0] fifo_key, fifo_dur;

    assign sda_bus  = sda_m & ~sda_oe;
    assign fifo_key = 8'hA0 + head;
    assign fifo_dur = 8'h40 + head;

    always #10 clk = ~clk;

    keyremote_i2c_slave dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus), .sda_oe(sda_oe),
        .addr_pins(addr_pins), .fifo_key(fifo_key), .fifo_dur(fifo_dur),
        .fifo_empty(fifo_empty), .fifo_pop(fifo_pop), .fifo_clear(fifo_clear),
        .force_en(force_en)
    );

    int n_chk = 0, n_bad = 0, pops = 0, clears = 0, oe_drift = 0;

    always @(posedge clk) begin
        if (fifo_pop) begin
            pops <= pops + 1;
            head <= head + 8'd1;
        end
        if (fifo_clear) clears <= clears + 1;
    end

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic w(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; w(Q); scl_m = 1'b1; w(Q); sda_m = 1'b0; w(Q); scl_m = 1'b0; w(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; w(Q); scl_m = 1'b1; w(Q); sda_m = 1'b1; w(Q);
    endtask

    task automatic put_bit(input logic b);
        sda_m = b; w(Q); scl_m = 1'b1; w(2 * Q); scl_m = 1'b0; w(Q);
    endtask

    task automatic get_bit(output logic b);
        logic early;
        sda_m = 1'b1; w(Q); scl_m = 1'b1; w(2);
        early = sda_bus; w(2 * Q - 4);
        b = sda_bus;
        if (b != early) oe_drift++;
        w(2); scl_m = 1'b0; w(Q);
    endtask

    task automatic put_byte(input logic [7:0] v, output logic nack);
        for (int i = 7; i >= 0; i--) put_bit(v[i]);
        get_bit(nack);
    endtask

    task automatic get_byte(input logic ack, output logic [7:0] v);
        for (int i = 7; i >= 0; i--) get_bit(v[i]);
        put_bit(~ack);
    endtask

    function automatic logic [7:0] addr_byte(input logic [1:0] a, input logic rd);
        return {5'b01000, a, rd};
    endfunction

    task automatic ctl_write(input logic [7:0] v, input string req);
        logic na;
        bus_start();
        put_byte(addr_byte(addr_pins, 1'b0), na); chk({req, " address ack"}, na, 0);
        put_byte(v, na);                          chk({req, " data ack"}, na, 0);
        bus_stop();
    endtask

    task automatic read_frame(input int nbytes, input logic last_ack, output logic [7:0] b [4]);
        logic na;
        bus_start();
        put_byte(addr_byte(addr_pins, 1'b1), na);
        chk("R1 read address ack", na, 0);
        for (int i = 0; i < nbytes; i++) get_byte((i == nbytes - 1) ? last_ack : 1'b1, b[i]);
        bus_stop();
    endtask

    task automatic t_reset();
        chk("R9 sda_oe after reset", sda_oe, 0);
        chk("R9 force_en after reset", force_en, 1);
        chk("R9 no pop after reset", pops, 0);
        chk("R9 no clear after reset", clears, 0);
    endtask

    task automatic t_mismatch();
        logic na;
        logic [7:0] junk;
        bus_start();
        put_byte(addr_byte(2'b10, 1'b1), na);
        chk("R1 foreign address not acked", na, 1);
        get_byte(1'b0, junk);
        chk("R1 line stays released after mismatch", junk, 8'hFF);
        bus_stop();
    endtask

    task automatic t_write_and_fields();
        logic [7:0] b [4];
        ctl_write(8'h00, "R4");
        chk("R4 force_en cleared by bit7=0", force_en, 0);
        ctl_write(8'h3F, "R7");
        chk("R7 low-bit write leaves force_en", force_en, 0);
        chk("R8 no clear when bit6=0", clears, 0);
        read_frame(4, 1'b1, b);
        chk("R5 chip id byte", b[0], 8'h00);
        chk("R7 control readback with low bits written", b[1], 8'h00);
        chk("R5 key byte", b[2], 8'hA0);
        chk("R5 duration byte", b[3], 8'h40);
        chk("R6 pop after acked duration", pops, 1);
        chk("R3 driven SDA stable while SCL high", oe_drift, 0);
    endtask

    task automatic t_clear();
        ctl_write(8'hC0, "R8");
        chk("R8 clear pulse is one cycle", clears, 1);
        chk("R4 force_en set by bit7=1", force_en, 1);
    endtask

    task automatic t_nack_retain();
        logic [7:0] b [4];
        read_frame(4, 1'b0, b);
        chk("R6 key before nack", b[2], 8'hA1);
        chk("R6 no pop on nack of duration", pops, 1);
        read_frame(2, 1'b0, b);
        chk("R7 control with force set", b[1], 8'h80);
        chk("R6 no pop on early stop", pops, 1);
        read_frame(4, 1'b1, b);
        chk("R6 same key after nack", b[2], 8'hA1);
        chk("R6 same duration after nack", b[3], 8'h41);
        chk("R6 pop after retried frame", pops, 2);
    endtask

    task automatic t_repeated_start();
        logic na;
        logic [7:0] b [4];
        bus_start();
        put_byte(addr_byte(addr_pins, 1'b0), na);
        put_byte(8'h80, na);
        chk("R2 write before repeated start acked", na, 0);
        bus_start();
        put_byte(addr_byte(addr_pins, 1'b1), na);
        chk("R2 address after repeated start acked", na, 0);
        for (int i = 0; i < 4; i++) get_byte(1'b1, b[i]);
        bus_stop();
        chk("R2 key after repeated start", b[2], 8'hA2);
        chk("R5 duration after repeated start", b[3], 8'h42);
        chk("R2 sda released after stop", sda_oe, 0);
    endtask

    task automatic t_empty_flag();
        logic [7:0] b [4];
        fifo_empty = 1'b1;
        read_frame(2, 1'b0, b);
        chk("R7 empty flag in bit5", b[1], 8'hA0);
        fifo_empty = 1'b0;
        chk("R3 driven SDA stable while SCL high", oe_drift, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        w(5);
        rst_n = 1'b1;
        w(5);
        t_reset();
        t_mismatch();
        t_write_and_fields();
        t_clear();
        t_nack_retain();
        t_repeated_start();
        t_empty_flag();
        w(10);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule